// File: doc/BRIEF.md
# Bit-Serial CRC-8 Checker for a Single-Wire Bus Master

This block checks data that a bus master has read from a device on a single-wire bus. Each received bit arrives on `bit_in` with a one-cycle `bit_valid` strobe, least significant bit of the first byte first. The block folds every accepted bit into an 8-bit register using the reflected form of x^8 + x^5 + x^4 + 1. Two frame lengths are supported. A device identifier has 56 data bits. A scratchpad has 64 data bits. In both cases the 8 received CRC bits follow the data.

After the clear, the block counts the accepted bits. Once the data bits and the CRC bits have all been absorbed, it raises `done`. It then reports `crc_ok` when the remaining register value is zero. A mismatch does not hold up anything: the block only reports the result, and the user decides whether to go on. The frame length is chosen by `mode_sel` and is captured when `clr` is asserted.

Top module: `owcrc_checker`

## Requirements
- R1: After reset `crc_val` is 0, `done` is 0, `crc_ok` is 0, and the captured frame mode is the identifier mode (64 bits).
- R2: An accepted bit updates the register as fb = bit_in ^ crc[0], crc = {fb, crc[7:1]} ^ (fb ? 8'h0C : 8'h00). For the identifier bytes 02 1C B8 01 00 00 00, sent LSB first, the register reads 8'hA2 after the 56th bit.
- R3: A cycle with `bit_valid` low changes neither `crc_val` nor `done`, whatever the value of `bit_in`.
- R4: With mode 0 (identifier) captured, `done` is low after 63 accepted bits and is high in the cycle after the 64th accepted bit.
- R5: With mode 1 (scratchpad) captured, `done` is still low after 64 accepted bits and is high in the cycle after the 72nd accepted bit.
- R6: `crc_ok` is high exactly when `done` is high and `crc_val` is zero. It is never high while `done` is low.
- R7: Once `done` is high, further strobed bits are ignored. `crc_val`, `done` and `crc_ok` hold their values until the next clear.
- R8: `clr` is synchronous. In the following cycle `crc_val` is 0, the bit count is 0 and `done` is 0. A bit strobed in the same cycle as `clr` is dropped. `mode_sel` is captured on `clr`.
- R9: A frame with a wrong bit still completes. `done` rises at the normal count, with `crc_ok` low and `crc_val` nonzero.
- R10: A change of `mode_sel` without a `clr` has no effect on the frame length already captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear and start of a new frame; captures `mode_sel` |
| mode_sel | input | 1 | Frame length select: 0 = identifier (56+8 bits), 1 = scratchpad (64+8 bits) |
| bit_in | input | 1 | Received data bit |
| bit_valid | input | 1 | Strobe: `bit_in` is taken in this cycle |
| crc_val | output | 8 | Current CRC register |
| done | output | 1 | All bits of the frame have been absorbed |
| crc_ok | output | 1 | Frame is complete and the remaining register value is zero |

## Verification
The bench checks the frame boundary on both sides. An off-by-one counter would raise `done` after 63 or 65 bits, or would stop a scratchpad frame at 64 bits. A wrong tap position or a bit order sent MSB first would miss the known 8'hA2 value for the identifier vector. The bench also sends bits after completion, drops the strobe between bits, and asserts clear together with a strobe. A design that kept shifting, sampled `bit_in` without the strobe, or let the strobe win over clear would change a register that should hold. The bench also flips a bit and changes the mode in the middle of a frame. This catches a design that withholds `done` on a mismatch or reads the mode live.

// File: rtl/owcrc_pkg.sv
package owcrc_pkg;

    typedef enum logic {
        FRAME_ID  = 1'b0,
        FRAME_PAD = 1'b1
    } owcrc_frame_e;

endpackage

// File: rtl/owcrc_step.sv
module owcrc_step #(
    parameter int               CRC_W     = 8,
    parameter logic [CRC_W-1:0] POLY_REFL = 8'h8C
) (
    input  logic [CRC_W-1:0] cur,
    input  logic             din,
    output logic [CRC_W-1:0] nxt
);
    logic fb;

    assign fb = din ^ cur[0];

    for (genvar i = 0; i < CRC_W; i++) begin : g_bit
        if (i == CRC_W - 1) begin : g_top
            assign nxt[i] = fb;
        end else begin : g_mid
            assign nxt[i] = cur[i+1] ^ (POLY_REFL[i] & fb);
        end
    end
endmodule

// File: rtl/owcrc_len_sel.sv
module owcrc_len_sel
    import owcrc_pkg::*;
#(
    parameter int CRC_W         = 8,
    parameter int ID_DATA_BITS  = 56,
    parameter int PAD_DATA_BITS = 64,
    parameter int CNT_W         = 7
) (
    input  owcrc_frame_e     frame,
    output logic [CNT_W-1:0] total
);
    localparam logic [CNT_W-1:0] ID_LEN  = CNT_W'(ID_DATA_BITS + CRC_W);
    localparam logic [CNT_W-1:0] PAD_LEN = CNT_W'(PAD_DATA_BITS + CRC_W);

    assign total = (frame == FRAME_PAD) ? PAD_LEN : ID_LEN;
endmodule

// File: rtl/owcrc_checker.sv
module owcrc_checker
    import owcrc_pkg::*;
#(
    parameter int         CRC_W         = 8,
    parameter logic [7:0] POLY_REFL     = 8'h8C,
    parameter int         ID_DATA_BITS  = 56,
    parameter int         PAD_DATA_BITS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             mode_sel,
    input  logic             bit_in,
    input  logic             bit_valid,
    output logic [CRC_W-1:0] crc_val,
    output logic             done,
    output logic             crc_ok
);
    localparam int MAX_BITS = (ID_DATA_BITS > PAD_DATA_BITS ? ID_DATA_BITS : PAD_DATA_BITS) + CRC_W;
    localparam int CNT_W    = $clog2(MAX_BITS + 1);

    typedef struct packed {
        logic [CRC_W-1:0] crc;
        logic [CNT_W-1:0] cnt;
        owcrc_frame_e     frame;
    } state_t;

    state_t           st_d, st_q;
    logic [CRC_W-1:0] crc_step;
    logic [CNT_W-1:0] total;
    logic             done_w;

    owcrc_step #(
        .CRC_W     (CRC_W),
        .POLY_REFL (POLY_REFL[CRC_W-1:0])
    ) u_step (
        .cur (st_q.crc),
        .din (bit_in),
        .nxt (crc_step)
    );

    owcrc_len_sel #(
        .CRC_W         (CRC_W),
        .ID_DATA_BITS  (ID_DATA_BITS),
        .PAD_DATA_BITS (PAD_DATA_BITS),
        .CNT_W         (CNT_W)
    ) u_len (
        .frame (st_q.frame),
        .total (total)
    );

    assign done_w = (st_q.cnt == total);

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.crc   = '0;
            st_d.cnt   = '0;
            st_d.frame = mode_sel ? FRAME_PAD : FRAME_ID;
        end else if (bit_valid && !done_w) begin
            st_d.crc = crc_step;
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{crc: '0, cnt: '0, frame: FRAME_ID};
        end else begin
            st_q <= st_d;
        end
    end

    assign crc_val = st_q.crc;
    assign done    = done_w;
    assign crc_ok  = done_w && (st_q.crc == '0);
endmodule

// File: rtl/owcrc_checker_props.sv
module owcrc_checker_props #(
    parameter int CRC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             bit_valid,
    input logic [CRC_W-1:0] crc_val,
    input logic             done,
    input logic             crc_ok
);
    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc_val == '0) && !done)
        else $error("R8: clear did not zero the state");

    p_ok_needs_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        crc_ok |-> done)
        else $error("R6: crc_ok high without done");

    p_ok_matches_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (crc_ok == (crc_val == '0)))
        else $error("R6: crc_ok disagrees with register");

    p_hold_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> (done && $stable(crc_val)))
        else $error("R7: state moved after done");

    p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_valid && !clr) |=> ($stable(crc_val) && $stable(done)))
        else $error("R3: state moved without strobe");

    p_done_rise_on_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(bit_valid))
        else $error("R4: done rose without an accepted bit");
endmodule

bind owcrc_checker owcrc_checker_props #(.CRC_W(CRC_W)) u_props (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .bit_valid (bit_valid),
    .crc_val   (crc_val),
    .done      (done),
    .crc_ok    (crc_ok)
);

// File: tb/owcrc_checker_test.sv
module owcrc_checker_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       mode_sel = 1'b0;
    logic       bit_in = 1'b0;
    logic       bit_valid = 1'b0;
    logic [7:0] crc_val;
    logic       done;
    logic       crc_ok;

    int n_checks = 0;
    int n_err    = 0;
    logic [7:0] frame [9];

    always #10 clk = ~clk;

    owcrc_checker uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .mode_sel  (mode_sel),
        .bit_in    (bit_in),
        .bit_valid (bit_valid),
        .crc_val   (crc_val),
        .done      (done),
        .crc_ok    (crc_ok)
    );

    function automatic logic [7:0] ref_crc(input int nbytes);
        logic [7:0] c = 8'h00;
        for (int k = 0; k < nbytes; k++) begin
            for (int b = 0; b < 8; b++) begin
                if (c[0] ^ frame[k][b]) c = (c >> 1) ^ 8'h8C;
                else                    c = c >> 1;
            end
        end
        return c;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_in    = b;
        bit_valid = 1'b1;
        @(negedge clk);
        bit_valid = 1'b0;
        bit_in    = ~b;
    endtask

    task automatic send_range(input int first, input int last);
        for (int i = first; i <= last; i++) send_bit(frame[i / 8][i % 8]);
    endtask

    task automatic do_clear(input logic m);
        @(negedge clk);
        mode_sel = m;
        clr      = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic load_id_vector();
        frame[0] = 8'h02; frame[1] = 8'h1C; frame[2] = 8'hB8; frame[3] = 8'h01;
        frame[4] = 8'h00; frame[5] = 8'h00; frame[6] = 8'h00; frame[7] = 8'hA2;
    endtask

    task automatic t_reset();
        chk("R1", "crc after reset", crc_val, 8'h00);
        chk("R1", "done after reset", done, 1'b0);
        chk("R1", "ok after reset", crc_ok, 1'b0);
    endtask

    task automatic t_id_vector();
        load_id_vector();
        do_clear(1'b0);
        send_range(0, 55);
        chk("R2", "crc after 56 id bits", crc_val, 8'hA2);
        chk("R6", "ok low before done", crc_ok, 1'b0);
        send_range(56, 62);
        chk("R4", "done after 63 bits", done, 1'b0);
        send_range(63, 63);
        chk("R4", "done after 64 bits", done, 1'b1);
        chk("R6", "ok on good id frame", crc_ok, 1'b1);
        chk("R6", "zero residual", crc_val, 8'h00);
    endtask

    task automatic t_after_done();
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        chk("R7", "crc held after done", crc_val, 8'h00);
        chk("R7", "done held", done, 1'b1);
        chk("R7", "ok held", crc_ok, 1'b1);
    endtask

    task automatic t_flip();
        logic [7:0] exp;
        load_id_vector();
        frame[2][1] = ~frame[2][1];
        exp = ref_crc(8);
        do_clear(1'b0);
        send_range(0, 63);
        chk("R9", "done on bad frame", done, 1'b1);
        chk("R9", "ok low on bad frame", crc_ok, 1'b0);
        chk("R2", "residual of bad frame", crc_val, exp);
        chk("R9", "residual nonzero", (crc_val != 8'h00), 1'b1);
    endtask

    task automatic t_pad();
        frame[0] = 8'h50; frame[1] = 8'h05; frame[2] = 8'h4B; frame[3] = 8'h46;
        frame[4] = 8'h7F; frame[5] = 8'hFF; frame[6] = 8'h0C; frame[7] = 8'h10;
        frame[8] = ref_crc(8);
        do_clear(1'b1);
        send_range(0, 63);
        chk("R5", "done after 64 pad bits", done, 1'b0);
        chk("R2", "crc after pad data", crc_val, frame[8]);
        send_range(64, 70);
        chk("R5", "done after 71 pad bits", done, 1'b0);
        send_range(71, 71);
        chk("R5", "done after 72 pad bits", done, 1'b1);
        chk("R6", "ok on good pad frame", crc_ok, 1'b1);
    endtask

    task automatic t_gaps();
        logic [7:0] snap;
        load_id_vector();
        do_clear(1'b0);
        send_range(0, 12);
        snap = crc_val;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            bit_in = i[0];
        end
        @(negedge clk);
        chk("R3", "crc held with strobe low", crc_val, snap);
        chk("R3", "done held with strobe low", done, 1'b0);
        send_range(13, 63);
        chk("R3", "ok after gapped frame", crc_ok, 1'b1);
    endtask

    task automatic t_mode_no_clear();
        load_id_vector();
        do_clear(1'b0);
        @(negedge clk);
        mode_sel = 1'b1;
        send_range(0, 63);
        chk("R10", "length kept after mode change", done, 1'b1);
        chk("R10", "ok with id length", crc_ok, 1'b1);
    endtask

    task automatic t_clear_mid();
        load_id_vector();
        do_clear(1'b0);
        send_range(0, 19);
        @(negedge clk);
        clr       = 1'b1;
        mode_sel  = 1'b0;
        bit_in    = 1'b1;
        bit_valid = 1'b1;
        @(negedge clk);
        clr       = 1'b0;
        bit_valid = 1'b0;
        chk("R8", "crc zero after clear with strobe", crc_val, 8'h00);
        chk("R8", "done low after clear", done, 1'b0);
        send_range(0, 62);
        chk("R8", "count restarted", done, 1'b0);
        send_range(63, 63);
        chk("R8", "full frame after clear", crc_ok, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_id_vector();
        t_after_done();
        t_flip();
        t_pad();
        t_gaps();
        t_mode_no_clear();
        t_clear_mid();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule